// File: doc/BRIEF.md
# Descriptor Reload Engine

This block runs the step that follows a DMA channel's transfer count running out. The channel sequencer hands it the channel number, the channel's current next-descriptor pointer and its current control word. If the pointer is zero, the engine tells the channel register file to drop the channel's enable. If the pointer is nonzero, the engine reads a four-word descriptor through a 32-bit memory read port. It writes each word into the channel register file as it arrives: source address, destination address, control word, and finally the new next-pointer.

When the reload step ends, the engine raises a terminal-count event if bit 31 of the control word now in effect is set. A read that comes back with an error abandons the descriptor. The engine then raises an error event and drops the channel's enable instead. Only one reload is handled at a time, and `busy` holds the sequencer off until the current one is finished.

Top module: `desc_reload_engine`

## Requirements
- R1: Out of reset, `busy`, `req_valid`, `rsp_ready`, `wr_valid`, `en_clr`, `tc_set` and `err_set` are all low.
- R2: A request on `start_valid` is accepted only while `busy` is low, and `busy` is high from the next cycle until the reload finishes. A `start_valid` raised while `busy` is high is ignored and leaves the running reload unchanged.
- R3: A zero pointer issues no memory read. In the cycle after acceptance, `en_clr` pulses for one cycle, and `tc_set` pulses with it exactly when bit 31 of `start_ctrl` is set.
- R4: A nonzero pointer P issues reads at P+0, P+4, P+12 and P+8, in that order, with at most one read outstanding. `req_valid` and `req_addr` hold until `req_ready` is seen.
- R5: Each good response is written out with `wr_valid` in the cycle it arrives, with its data unchanged (bits 7:0 hold the lowest-addressed byte of the word). The select code is 0 for the word from P+0 (source), 1 for P+4 (destination), 2 for P+12 (control) and 3 for P+8 (next-pointer), so the next-pointer is the last word written.
- R6: After all four words have been written, `tc_set` pulses one cycle later exactly when bit 31 of the fetched control word is set, and `en_clr` stays low.
- R7: A response with `rsp_err` high is not written. No further reads are issued, and in the next cycle `err_set` and `en_clr` pulse together while `tc_set` stays low.
- R8: Every write and every event carries, on `op_chan`, the channel number that was accepted with the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Count-expired request from the channel sequencer |
| start_chan | input | CW | Channel index of the request |
| start_link | input | AW | Channel's current next-descriptor pointer |
| start_ctrl | input | DW | Channel's current control word |
| busy | output | 1 | Reload in progress; new requests are ignored |
| req_valid | output | 1 | Memory read request valid |
| req_addr | output | AW | Memory read byte address |
| req_ready | input | 1 | Memory accepts the read request |
| rsp_valid | input | 1 | Memory read data valid |
| rsp_data | input | DW | Memory read data, little-endian word |
| rsp_err | input | 1 | Memory read error, qualified by rsp_valid |
| rsp_ready | output | 1 | Engine accepts read data |
| wr_valid | output | 1 | Register file write strobe |
| wr_sel | output | 2 | Register select: 0 source, 1 destination, 2 control, 3 next-pointer |
| wr_data | output | DW | Register write data |
| en_clr | output | 1 | Clear the channel's enable bit |
| tc_set | output | 1 | Set the channel's raw terminal-count flag |
| err_set | output | 1 | Set the channel's raw error flag |
| op_chan | output | CW | Channel that the write or event applies to |

## Verification
The bench goes after the fetch order. A design that walked the descriptor in address order would write the next-pointer before the control word, or would load it from offset 12. It also targets the source of the terminal-count decision: a design that tested the old control word after a reload, or the fetched one on a zero pointer, would flag the wrong cycle. Errors are injected on the first and on the last fetch, to catch a write of bad data, a read issued after the fault, or a stray terminal-count event. Requests raised while busy, together with random memory stalls, expose a design that restarts in mid-descriptor or drops a held read request.

// File: rtl/dre_pkg.sv
package dre_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REQ   = 3'd1,
    ST_WAIT  = 3'd2,
    ST_TERM  = 3'd3,
    ST_DONE  = 3'd4,
    ST_FAULT = 3'd5
  } dre_state_e;

  // Step index equals the register select code; the step order fixes the
  // write order, with the next-pointer last.
  typedef enum logic [1:0] {
    FLD_SRC  = 2'd0,
    FLD_DST  = 2'd1,
    FLD_CTRL = 2'd2,
    FLD_NEXT = 2'd3
  } dre_field_e;

  localparam int unsigned DRE_STEPS = 4;
  localparam int unsigned DRE_STEP_W = $clog2(DRE_STEPS);

  // Word offset of each field inside a descriptor in memory.
  function automatic logic [3:0] field_word_off(input dre_field_e f);
    case (f)
      FLD_SRC:  field_word_off = 4'd0;
      FLD_DST:  field_word_off = 4'd1;
      FLD_NEXT: field_word_off = 4'd2;
      default:  field_word_off = 4'd3;
    endcase
  endfunction

endpackage

// File: rtl/dre_addr_gen.sv
module dre_addr_gen
  import dre_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0]         base,
  input  logic [DRE_STEP_W-1:0] step,
  output dre_field_e            field,
  output logic [AW-1:0]         addr
);

  localparam int unsigned BYTE_SHIFT = 2;

  logic [AW-1:0] byte_off;

  always_comb begin
    field    = dre_field_e'(step);
    byte_off = '0;
    byte_off[BYTE_SHIFT +: 4] = field_word_off(field);
    addr     = base + byte_off;
  end

endmodule

// File: rtl/dre_seq.sv
module dre_seq
  import dre_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned DW     = 32,
  parameter int unsigned CW     = 3,
  parameter int unsigned TC_BIT = 31
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_valid,
  input  logic [CW-1:0]         start_chan,
  input  logic [AW-1:0]         start_link,
  input  logic [DW-1:0]         start_ctrl,
  input  logic                  req_ready,
  input  logic                  rsp_valid,
  input  logic [DW-1:0]         rsp_data,
  input  logic                  rsp_err,
  input  dre_field_e            cur_field,
  output logic [AW-1:0]         link_base,
  output logic [DRE_STEP_W-1:0] step,
  output logic                  busy,
  output logic                  req_valid,
  output logic                  rsp_ready,
  output logic                  wr_valid,
  output logic [DW-1:0]         wr_data,
  output logic                  en_clr,
  output logic                  tc_set,
  output logic                  err_set,
  output logic [CW-1:0]         op_chan
);

  localparam logic [DRE_STEP_W-1:0] LAST_STEP = DRE_STEP_W'(DRE_STEPS - 1);

  dre_state_e            state_q, state_d;
  logic [DRE_STEP_W-1:0] step_q, step_d;
  logic [CW-1:0]         chan_q;
  logic [AW-1:0]         link_q;
  logic [DW-1:0]         ctrl_q, ctrl_d;
  logic                  accept;
  logic                  good_rsp;
  logic                  ctrl_en;

  assign accept   = (state_q == ST_IDLE) && start_valid;
  assign good_rsp = (state_q == ST_WAIT) && rsp_valid && !rsp_err;
  assign ctrl_en  = accept || (good_rsp && cur_field == FLD_CTRL);

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    case (state_q)
      ST_IDLE: begin
        if (start_valid) begin
          step_d  = '0;
          state_d = (start_link == '0) ? ST_TERM : ST_REQ;
        end
      end
      ST_REQ: begin
        if (req_ready) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (rsp_valid) begin
          if (rsp_err) begin
            state_d = ST_FAULT;
          end else if (step_q == LAST_STEP) begin
            state_d = ST_DONE;
          end else begin
            step_d  = step_q + 1'b1;
            state_d = ST_REQ;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    ctrl_d = ctrl_q;
    if (accept)        ctrl_d = start_ctrl;
    else if (good_rsp) ctrl_d = rsp_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
      link_q <= '0;
    end else if (accept) begin
      chan_q <= start_chan;
      link_q <= start_link;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  assign link_base = link_q;
  assign step      = step_q;
  assign busy      = (state_q != ST_IDLE);
  assign req_valid = (state_q == ST_REQ);
  assign rsp_ready = (state_q == ST_WAIT);
  assign wr_valid  = good_rsp;
  assign wr_data   = rsp_data;
  assign en_clr    = (state_q == ST_TERM) || (state_q == ST_FAULT);
  assign err_set   = (state_q == ST_FAULT);
  assign tc_set    = ((state_q == ST_TERM) || (state_q == ST_DONE)) && ctrl_q[TC_BIT];
  assign op_chan   = chan_q;

  // R2: an accepted request makes the engine busy in the next cycle
  a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && !busy) |=> busy);

  // R2: the channel held for the operation is stable while busy
  a_r2_chan_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(op_chan));

  // R4: a stalled read request keeps its valid
  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> req_valid);

  // R5: nothing is read or written after the next-pointer write
  a_r5_next_last: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && cur_field == FLD_NEXT) |=> (!wr_valid && !req_valid));

  // R7: a fault always drops the channel enable and never flags terminal count
  a_r7_fault_events: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |-> (en_clr && !tc_set));

  // R7: an error response is followed by the error event
  a_r7_err_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && rsp_err) |=> err_set);

endmodule

// File: rtl/desc_reload_engine.sv
module desc_reload_engine
  import dre_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned DW     = 32,
  parameter int unsigned CW     = 3,
  parameter int unsigned TC_BIT = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_valid,
  input  logic [CW-1:0] start_chan,
  input  logic [AW-1:0] start_link,
  input  logic [DW-1:0] start_ctrl,
  output logic          busy,
  output logic          req_valid,
  output logic [AW-1:0] req_addr,
  input  logic          req_ready,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  input  logic          rsp_err,
  output logic          rsp_ready,
  output logic          wr_valid,
  output logic [1:0]    wr_sel,
  output logic [DW-1:0] wr_data,
  output logic          en_clr,
  output logic          tc_set,
  output logic          err_set,
  output logic [CW-1:0] op_chan
);

  logic [AW-1:0]         link_base;
  logic [DRE_STEP_W-1:0] step;
  dre_field_e            cur_field;

  dre_addr_gen #(.AW(AW)) u_addr (
    .base  (link_base),
    .step  (step),
    .field (cur_field),
    .addr  (req_addr)
  );

  dre_seq #(.AW(AW), .DW(DW), .CW(CW), .TC_BIT(TC_BIT)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_valid (start_valid),
    .start_chan  (start_chan),
    .start_link  (start_link),
    .start_ctrl  (start_ctrl),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data),
    .rsp_err     (rsp_err),
    .cur_field   (cur_field),
    .link_base   (link_base),
    .step        (step),
    .busy        (busy),
    .req_valid   (req_valid),
    .rsp_ready   (rsp_ready),
    .wr_valid    (wr_valid),
    .wr_data     (wr_data),
    .en_clr      (en_clr),
    .tc_set      (tc_set),
    .err_set     (err_set),
    .op_chan     (op_chan)
  );

  assign wr_sel = cur_field;

  // R4: a stalled read request keeps its address
  a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> $stable(req_addr));

  // R3: terminal events are only raised once no read is in flight
  a_r3_no_req_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    (en_clr || tc_set) |-> (!req_valid && !rsp_ready));

endmodule

// File: tb/desc_reload_engine_tb_top.sv
module desc_reload_engine_tb_top;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_valid;
  logic [CW-1:0] start_chan;
  logic [AW-1:0] start_link;
  logic [DW-1:0] start_ctrl;
  logic          busy, req_valid, req_ready, rsp_valid, rsp_err, rsp_ready;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] rsp_data, wr_data;
  logic          wr_valid, en_clr, tc_set, err_set;
  logic [1:0]    wr_sel;
  logic [CW-1:0] op_chan;

  always #5 clk = ~clk;

  desc_reload_engine #(.AW(AW), .DW(DW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_chan(start_chan),
    .start_link(start_link), .start_ctrl(start_ctrl), .busy(busy),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .rsp_ready(rsp_ready), .wr_valid(wr_valid), .wr_sel(wr_sel),
    .wr_data(wr_data), .en_clr(en_clr), .tc_set(tc_set), .err_set(err_set),
    .op_chan(op_chan)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] memword(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A17C3E9;
  endfunction

  function automatic logic [31:0] step_off(input int s);
    case (s)
      0: return 32'd0;
      1: return 32'd4;
      2: return 32'd12;
      default: return 32'd8;
    endcase
  endfunction

  // memory responder state
  bit          err_en = 1'b0;
  logic [31:0] err_addr = '0;
  bit          pend = 1'b0;
  logic [31:0] pend_addr = '0;
  int          pend_cnt = 0;
  bit          rsp_not_ready = 1'b0;

  initial begin
    req_ready = 1'b0;
    rsp_valid = 1'b0;
    rsp_data  = '0;
    rsp_err   = 1'b0;
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      rsp_err   = 1'b0;
      if (pend && pend_cnt == 0) begin
        rsp_valid = 1'b1;
        rsp_data  = memword(pend_addr);
        rsp_err   = err_en && (pend_addr == err_addr);
        pend      = 1'b0;
        if (!rsp_ready) rsp_not_ready = 1'b1;
      end else if (pend) begin
        pend_cnt--;
      end
      req_ready = (!pend && !rsp_valid) ? (($urandom % 3) != 0) : 1'b0;
      if (req_valid && req_ready) begin
        pend      = 1'b1;
        pend_addr = req_addr;
        pend_cnt  = $urandom % 3;
      end
    end
  end

  // monitor, sampled mid-cycle
  logic [31:0] m_req [8];
  logic [1:0]  m_sel [8];
  logic [31:0] m_dat [8];
  int n_req, n_wr, n_tc, n_clr, n_err, n_badchan;
  logic [CW-1:0] exp_chan;

  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (req_valid && req_ready) begin
        if (n_req < 8) m_req[n_req] = req_addr;
        n_req++;
      end
      if (wr_valid) begin
        if (n_wr < 8) begin m_sel[n_wr] = wr_sel; m_dat[n_wr] = wr_data; end
        n_wr++;
      end
      if (tc_set)  n_tc++;
      if (en_clr)  n_clr++;
      if (err_set) n_err++;
      if ((wr_valid || tc_set || en_clr || err_set) && op_chan != exp_chan) n_badchan++;
    end
  end

  task automatic run_op(input logic [CW-1:0] ch, input logic [31:0] link,
                        input logic [31:0] ctrl, input int err_step, input bit poke);
    int exp_rd, exp_wr, exp_tc;
    bit e;
    e        = (err_step >= 0) && (link != 0);
    err_en   = e;
    err_addr = link + step_off(err_step < 0 ? 0 : err_step);
    exp_chan = ch;
    n_req = 0; n_wr = 0; n_tc = 0; n_clr = 0; n_err = 0; n_badchan = 0;
    @(negedge clk);
    start_valid = 1'b1; start_chan = ch; start_link = link; start_ctrl = ctrl;
    @(negedge clk);
    start_valid = 1'b0;
    #1;
    chk(busy == 1'b1, "R2", "busy after accept", busy, 1);
    if (poke && link != 0) begin
      start_valid = 1'b1; start_chan = ch ^ 3'd1; start_link = 32'h40; start_ctrl = ~ctrl;
      @(negedge clk);
      start_valid = 1'b0;
    end
    while (busy) @(negedge clk);
    #3;
    exp_rd = (link == 0) ? 0 : (e ? err_step + 1 : 4);
    exp_wr = (link == 0) ? 0 : (e ? err_step : 4);
    exp_tc = e ? 0 : ((link == 0) ? int'(ctrl[31]) : int'(memword(link + 32'd12) >> 31));
    chk(n_req == exp_rd, "R4", "read count", n_req, exp_rd);
    for (int i = 0; i < exp_rd && i < n_req; i++)
      chk(m_req[i] == link + step_off(i), "R4", "read address", m_req[i], link + step_off(i));
    chk(n_wr == exp_wr, "R5", "write count", n_wr, exp_wr);
    for (int i = 0; i < exp_wr && i < n_wr; i++) begin
      chk(m_sel[i] == 2'(i), "R5", "write select", m_sel[i], i);
      chk(m_dat[i] == memword(link + step_off(i)), "R5", "write data",
          m_dat[i], memword(link + step_off(i)));
    end
    if (link == 0)
      chk(n_tc == exp_tc, "R3", "tc on zero link", n_tc, exp_tc);
    else if (e)
      chk(n_tc == 0, "R7", "tc after fault", n_tc, 0);
    else
      chk(n_tc == exp_tc, "R6", "tc after reload", n_tc, exp_tc);
    chk(n_clr == ((link == 0 || e) ? 1 : 0), (e ? "R7" : (link == 0 ? "R3" : "R6")),
        "enable clear", n_clr, (link == 0 || e) ? 1 : 0);
    chk(n_err == (e ? 1 : 0), "R7", "error event", n_err, e ? 1 : 0);
    chk(n_badchan == 0, "R8", "channel tag", n_badchan, 0);
    chk(!rsp_not_ready, "R4", "data accepted", rsp_not_ready, 0);
    err_en = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1357));
    rst_n = 1'b0;
    start_valid = 1'b0; start_chan = '0; start_link = '0; start_ctrl = '0;
    exp_chan = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !req_valid && !rsp_ready && !wr_valid && !en_clr && !tc_set && !err_set,
        "R1", "reset outputs", {busy, req_valid, rsp_ready, wr_valid, en_clr, tc_set, err_set}, 0);
    rst_n = 1'b1;
    // directed corners
    run_op(3'd2, 32'h0, 32'h8000_0005, -1, 1'b0);   // R3 with tc
    run_op(3'd5, 32'h0, 32'h0000_0005, -1, 1'b0);   // R3 without tc
    run_op(3'd7, 32'h0000_1000, 32'h8000_0000, -1, 1'b0); // R5 R6 full reload
    run_op(3'd1, 32'h0000_2000, 32'h0, 0, 1'b0);    // R7 on first fetch
    run_op(3'd4, 32'h0000_3000, 32'h0, 3, 1'b0);    // R7 on last fetch
    run_op(3'd6, 32'h0000_4000, 32'h8000_0000, -1, 1'b1); // R2 ignored start
    // random mix
    for (int k = 0; k < 60; k++) begin
      logic [31:0] lk;
      int es;
      lk = (($urandom % 5) == 0) ? 32'h0 : ($urandom & 32'hFFFF_FFF0);
      es = (($urandom % 5) == 0) ? int'($urandom % 4) : -1;
      run_op(CW'($urandom), lk, $urandom, es, ($urandom % 2) == 1);
    end
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(10 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule